// File: doc/BRIEF.md
# Hard-Fault and Warning Protection Manager

This block gathers the fault inputs of a power inverter, for example overcurrent comparator outputs, gate-driver desaturation flags and the error raised when the controller misses its synchronization slot. It sorts them into two severity classes. A source in the hard class opens every power switch in the same clock cycle through a combinational kill path. It stops the modulator and puts the block into a latched error state. A source in the warning class leaves the inverter running and only sets a sticky status bit that the controller reads.

A class register holds a two-bit code for each source. The code marks the source as ignored, warning or hard. Two parameters override that register. Sources in `HARD_LOCK` are always hard, which is how the overrun error is handled. Sources in `WARN_ONLY` can never be more than a warning, because the gate driver has already acted on its own for those. Status bits are cleared by writing ones. The error state ends only after an explicit clear command given while no hard source is active. A capture register records which hard source tripped first.

Top module: `fault_guard`

## Requirements
- R1: Each source has a two-bit class field at bits [2i+1:2i]. The codes are 00 = ignored, 01 = warning, 10 and 11 = hard. After reset every field holds 10. A write through `cls_we_i` / `cls_wdata_i` takes effect from the next clock cycle.
- R2: While any source whose effective class is hard is active, `kill_o` is 1 and `mod_run_o` is 0 in that same cycle, with no clock edge in between.
- R3: An active hard source sets `err_o` at the next edge. While `err_o` is 1, `kill_o` stays 1 and `mod_run_o` stays 0, even after every source has gone inactive.
- R4: An active warning source sets its bit in `warn_sts_o` at the next edge. It raises neither `kill_o` nor `err_o`.
- R5: An ignored source changes no output.
- R6: Bits in `hard_sts_o` and `warn_sts_o` are sticky. A 1 on the matching bit of `hard_clr_i` / `warn_clr_i` clears the bit at the next edge. If the source is still active in that cycle, the bit stays set.
- R7: `err_o` falls at the next edge only when `err_clr_i` is 1 and no hard source is active in that cycle. Otherwise it holds.
- R8: On the first hard trip after reset or after an error exit, `first_src_o` takes the lowest index among the active hard sources, and `first_vld_o` rises. Both hold until the error exit, which returns them to 0.
- R9: Sources in `HARD_LOCK` (default: source 7, the overrun error) act as hard whatever their class field holds.
- R10: Sources in `WARN_ONLY` (default: sources 4 and 5, the desaturation flags) act as warnings when their field says hard. They never raise `kill_o` or `err_o`.
- R11: After reset all status, error and capture outputs are 0, `kill_o` is 0 and `mod_run_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Synchronized fault levels, active high |
| cls_we_i | input | 1 | Class register write strobe |
| cls_wdata_i | input | 2*N_SRC | New class fields |
| hard_clr_i | input | N_SRC | Write-one-to-clear for hard status |
| warn_clr_i | input | N_SRC | Write-one-to-clear for warning status |
| err_clr_i | input | 1 | Request to leave the error state |
| kill_o | output | 1 | Open all switches (combinational from hard sources) |
| mod_run_o | output | 1 | Modulator enable |
| err_o | output | 1 | Latched error state |
| hard_sts_o | output | N_SRC | Sticky hard-fault status |
| warn_sts_o | output | N_SRC | Sticky warning status |
| first_vld_o | output | 1 | First-fault capture valid |
| first_src_o | output | $clog2(N_SRC) | Index of the first tripping source |

## Verification
The assertions check on every cycle the properties that do not depend on stored configuration. They cover the locked overrun source forcing a kill, warning-only sources never killing on their own, the error state holding while not cleared or while a hard source is active, sticky status bits surviving cycles with no clear, and the first-fault index staying stable. The bench scenarios are what show the effects of class-register writes. These include the one-cycle delay before a new class applies, ignored and warning sources, W1C clears that race an active source, and the lowest-index choice when several sources trip together.

// File: rtl/fault_guard.sv
module fault_guard #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] HARD_LOCK = 8'h80,
  parameter logic [N_SRC-1:0] WARN_ONLY = 8'h30,
  parameter logic [2*N_SRC-1:0] CLS_RESET = {N_SRC{2'b10}},
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_i,
  input  logic               cls_we_i,
  input  logic [2*N_SRC-1:0] cls_wdata_i,
  input  logic [N_SRC-1:0]   hard_clr_i,
  input  logic [N_SRC-1:0]   warn_clr_i,
  input  logic               err_clr_i,
  output logic               kill_o,
  output logic               mod_run_o,
  output logic               err_o,
  output logic [N_SRC-1:0]   hard_sts_o,
  output logic [N_SRC-1:0]   warn_sts_o,
  output logic               first_vld_o,
  output logic [IDX_W-1:0]   first_src_o
);

  logic [2*N_SRC-1:0] cls_q;
  logic [N_SRC-1:0]   is_hard, is_warn, hard_act, warn_act;
  logic               err_q, vld_q;
  logic [IDX_W-1:0]   first_q, lowest;
  logic               any_hard;

  for (genvar i = 0; i < N_SRC; i++) begin : g_cls
    logic [1:0] f;
    assign f = cls_q[2*i +: 2];
    if (HARD_LOCK[i]) begin : g_lock
      assign is_hard[i] = 1'b1;
      assign is_warn[i] = 1'b0;
    end else if (WARN_ONLY[i]) begin : g_cap
      assign is_hard[i] = 1'b0;
      assign is_warn[i] = |f;
    end else begin : g_free
      assign is_hard[i] = f[1];
      assign is_warn[i] = (f == 2'b01);
    end
  end

  assign hard_act = src_i & is_hard;
  assign warn_act = src_i & is_warn;
  assign any_hard = |hard_act;

  always_comb begin
    lowest = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (hard_act[i]) lowest = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cls_q <= CLS_RESET;
    else if (cls_we_i) cls_q <= cls_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_sts_o <= '0;
      warn_sts_o <= '0;
    end else begin
      hard_sts_o <= (hard_sts_o & ~hard_clr_i) | hard_act;
      warn_sts_o <= (warn_sts_o & ~warn_clr_i) | warn_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      vld_q   <= 1'b0;
      first_q <= '0;
    end else if (any_hard) begin
      err_q <= 1'b1;
      if (!vld_q) begin
        vld_q   <= 1'b1;
        first_q <= lowest;
      end
    end else if (err_clr_i) begin
      err_q   <= 1'b0;
      vld_q   <= 1'b0;
      first_q <= '0;
    end
  end

  assign kill_o      = any_hard | err_q;
  assign mod_run_o   = ~kill_o;
  assign err_o       = err_q;
  assign first_vld_o = vld_q;
  assign first_src_o = first_q;

endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] HARD_LOCK = 8'h80,
  parameter logic [N_SRC-1:0] WARN_ONLY = 8'h30,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_i,
  input logic [N_SRC-1:0] hard_clr_i,
  input logic             err_clr_i,
  input logic             kill_o,
  input logic             err_o,
  input logic [N_SRC-1:0] hard_sts_o,
  input logic             first_vld_o,
  input logic [IDX_W-1:0] first_src_o,
  input logic [N_SRC-1:0] hard_act
);

  a_r3_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|hard_act) |=> err_o);

  a_r3_kill_in_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> kill_o);

  a_r7_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && (!err_clr_i || (|hard_act))) |=> err_o);

  a_r9_lock_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_i & HARD_LOCK)) |-> kill_o);

  a_r10_capped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (((src_i & ~WARN_ONLY) == '0) && !err_o) |-> !kill_o);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_clr_i == '0) |=> ((hard_sts_o & $past(hard_sts_o)) == $past(hard_sts_o)));

  a_r8_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (first_vld_o && !err_clr_i) |=> (first_vld_o && $stable(first_src_o)));

endmodule

bind fault_guard fault_guard_chk #(
  .N_SRC(N_SRC), .HARD_LOCK(HARD_LOCK), .WARN_ONLY(WARN_ONLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .hard_clr_i(hard_clr_i),
  .err_clr_i(err_clr_i), .kill_o(kill_o), .err_o(err_o),
  .hard_sts_o(hard_sts_o), .first_vld_o(first_vld_o),
  .first_src_o(first_src_o), .hard_act(hard_act)
);

// File: tb/fault_guard_test.sv
module fault_guard_test;
  localparam int N = 8;
  localparam logic [N-1:0] LOCK = 8'h80;
  localparam logic [N-1:0] CAP  = 8'h30;

  typedef struct packed {
    logic kill, run, err;
    logic [N-1:0] hs, ws;
    logic vld;
    logic [2:0] first;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0, hclr = '0, wclr = '0;
  logic cls_we = 0, eclr = 0;
  logic [2*N-1:0] cls_wd = '0;
  logic kill, run, err, vld;
  logic [N-1:0] hs, ws;
  logic [2:0] first;

  always #5 clk = ~clk;

  fault_guard uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .cls_we_i(cls_we), .cls_wdata_i(cls_wd),
    .hard_clr_i(hclr), .warn_clr_i(wclr), .err_clr_i(eclr),
    .kill_o(kill), .mod_run_o(run), .err_o(err), .hard_sts_o(hs), .warn_sts_o(ws),
    .first_vld_o(vld), .first_src_o(first)
  );

  exp_t  q_exp[$];
  string q_tag[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [2*N-1:0] m_cls = {N{2'b10}};
  logic [N-1:0] m_hs = '0, m_ws = '0;
  logic m_err = 0, m_vld = 0;
  logic [2:0] m_first = '0;

  task automatic drive(input logic [N-1:0] s, input logic [N-1:0] hc,
                       input logic [N-1:0] wc, input logic ec, input logic we,
                       input logic [2*N-1:0] wd, input string tag);
    logic [N-1:0] eh, ew, hn, wn;
    exp_t e;
    @(negedge clk);
    src = s; hclr = hc; wclr = wc; eclr = ec; cls_we = we; cls_wd = wd;
    for (int i = 0; i < N; i++) begin
      logic [1:0] f;
      f = m_cls[2*i +: 2];
      eh[i] = LOCK[i] | (!CAP[i] & f[1]);
      ew[i] = !eh[i] & (CAP[i] ? (f != 2'b00) : (f == 2'b01));
    end
    hn = s & eh; wn = s & ew;
    e.kill = (|hn) | m_err; e.run = !e.kill; e.err = m_err;
    e.hs = m_hs; e.ws = m_ws; e.vld = m_vld; e.first = m_first;
    q_exp.push_back(e); q_tag.push_back(tag);
    m_hs = (m_hs & ~hc) | hn;
    m_ws = (m_ws & ~wc) | wn;
    if (|hn) begin
      if (!m_vld) begin
        m_vld = 1;
        for (int i = N - 1; i >= 0; i--) if (hn[i]) m_first = 3'(i);
      end
      m_err = 1;
    end else if (ec) begin
      m_err = 0; m_vld = 0; m_first = '0;
    end
    if (we) m_cls = wd;
  endtask

  task automatic idle(input logic [N-1:0] s, input string tag);
    drive(s, '0, '0, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (q_exp.size() > 0) begin
        exp_t e;
        string t;
        exp_t g;
        e = q_exp.pop_front(); t = q_tag.pop_front();
        g = {kill, run, err, hs, ws, vld, first};
        checks++;
        if (g !== e) begin
          errors++;
          $display("FAIL %s: actual kill=%b run=%b err=%b hs=%h ws=%h vld=%b first=%0d expected kill=%b run=%b err=%b hs=%h ws=%h vld=%b first=%0d",
                   t, g.kill, g.run, g.err, g.hs, g.ws, g.vld, g.first,
                   e.kill, e.run, e.err, e.hs, e.ws, e.vld, e.first);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle('0, "R11 reset state");
    // R2 kill in the same cycle, R3 latch, R8 capture
    idle(8'h01, "R2 hard src0 same-cycle kill");
    idle(8'h00, "R3 error holds after source drops");
    idle(8'h00, "R8 first fault src0");
    // R7 clear refused while hard source active
    drive(8'h01, '0, '0, 1'b1, 1'b0, '0, "R7 clear with hard active");
    idle(8'h00, "R7 error still set");
    drive(8'h00, 8'h01, '0, 1'b1, 1'b0, '0, "R7 clear accepted");
    idle(8'h00, "R7 error left, R6 hard bit cleared");
    // R1 class write: src1 warning, src2 ignored, src7 ignored (locked), src4 hard (capped)
    drive(8'h02, '0, '0, 1'b0, 1'b1, 16'b00_10_10_10_10_00_01_10,
          "R1 old class applies in write cycle");
    idle(8'h00, "R1 src1 was hard before write");
    drive(8'h00, 8'h02, '0, 1'b1, 1'b0, '0, "R1 clean up");
    idle(8'h02, "R4 warning no kill");
    idle(8'h00, "R4 warning status set");
    idle(8'h04, "R5 ignored source");
    idle(8'h00, "R5 no trace left");
    // R6 W1C races
    drive(8'h02, '0, 8'h02, 1'b0, 1'b0, '0, "R6 clear while active");
    idle(8'h00, "R6 bit kept set");
    drive(8'h00, '0, 8'h02, 1'b0, 1'b0, '0, "R6 clear while idle");
    idle(8'h00, "R6 bit cleared");
    // R10 capped sources
    idle(8'h30, "R10 desat no kill");
    idle(8'h00, "R10 desat warning status");
    drive(8'h00, '0, 8'h30, 1'b0, 1'b0, '0, "R10 clean up");
    // R9 locked source despite ignore code
    idle(8'h80, "R9 overrun kills");
    idle(8'h00, "R9 error latched, first=7");
    drive(8'h00, 8'h80, '0, 1'b1, 1'b0, '0, "R9 clean up");
    // R8 simultaneous trip picks lowest index, later trip ignored
    idle(8'h48, "R8 simultaneous src3 src6");
    idle(8'h01, "R8 later src0 does not replace");
    idle(8'h00, "R8 first stays 3");
    drive(8'h00, 8'h49, '0, 1'b1, 1'b0, '0, "R8 exit clears capture");
    idle(8'h00, "R11 back to idle");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule